// File: doc/BRIEF.md
# Interrupt Pending Priority Selector

This block decides, every clock, whether a hart should take an interrupt and, if so, which one. It holds the pending-interrupt register, which is updated through a bit mask, and combines it with an enable vector, a delegation mask, the current privilege level and the two global enable bits (machine and supervisor). Each candidate line is qualified by the enable of the level that would service it. Among the surviving lines, the one with the lowest index wins. The decision and its cause number leave the block through registers.

The block also keeps an ownership register that records which pending lines are driven by hardware sources. A request to own a set of lines is granted only if none of those lines is owned already. A refused request leaves the register as it was. The result of each request is reported one cycle later.

Privilege is a 2-bit code: user = 0, supervisor = 1, machine = 3. Code 2 is treated by the same comparisons as the others: it counts as below machine and as neither below nor equal to supervisor.

Top module: `irq_pick`

## Requirements
- R1: A line can be chosen only if its bit is set both in the pending register and in `enableBits`. A line with either bit clear is never reported.
- R2: A non-delegated line (`delegMask` bit 0) is allowed through when `privLevel` is below 3, or when `privLevel` is 3 and `mGlobalEn` is 1.
- R3: A delegated line (`delegMask` bit 1) is allowed through when `privLevel` is 0, or when `privLevel` is 1 and `sGlobalEn` is 1. At `privLevel` 2 or 3, delegated lines are blocked.
- R4: Each line is qualified only by the level its `delegMask` bit selects. The other level's enable has no effect on that line.
- R5: When several lines survive qualification, `causeOut` is the index of the least significant surviving line.
- R6: When no line survives, `takeIrq` is 0 and `causeOut` is 0.
- R7: On `claimReq`, if `claimBits` overlaps `claimedOut`, the request is refused and `claimedOut` is unchanged. Otherwise `claimedOut` becomes `claimedOut | claimBits`. One cycle later `claimDone` pulses and `claimOk` shows the outcome.
- R8: With `pendWrEn` high, the pending register becomes `(old & ~pendMask) | (pendValue & pendMask)` at the clock edge, and `pendingOut` shows the new value. With `pendWrEn` low, the register holds its value.
- R9: `takeIrq` and `causeOut` reflect the inputs and the pending register as sampled at the previous clock edge.
- R10: After reset, the pending register, the ownership register, `takeIrq`, `causeOut`, `claimDone` and `claimOk` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pendWrEn | input | 1 | Apply a masked update to the pending register |
| pendMask | input | 16 | Bits of the pending register to overwrite |
| pendValue | input | 16 | New values for the masked bits |
| enableBits | input | 16 | Per-line interrupt enable |
| delegMask | input | 16 | 1 = line is serviced at supervisor level |
| privLevel | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| mGlobalEn | input | 1 | Global machine interrupt enable |
| sGlobalEn | input | 1 | Global supervisor interrupt enable |
| claimReq | input | 1 | Request ownership of the lines in `claimBits` |
| claimBits | input | 16 | Lines requested |
| pendingOut | output | 16 | Current pending register |
| claimedOut | output | 16 | Current ownership register |
| claimDone | output | 1 | Pulses one cycle after a request |
| claimOk | output | 1 | Request granted (valid with `claimDone`) |
| takeIrq | output | 1 | An interrupt should be taken |
| causeOut | output | 4 | Index of the chosen line |

## Verification
The hardest cases to reach are the mixed ones. In these, a lower-numbered line is blocked by its own level while a higher-numbered line is allowed by the other level. The priority result then depends on delegation and privilege together, not on the bit order alone. The bench reaches them with a sweep. It covers every privilege code, both global enables, and a set of pending, enable and delegation patterns. The patterns deliberately interleave delegated and non-delegated bits below and above each other. The expected cause is computed arithmetically for each combination.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;
  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_SUPER = 2'd1;
  localparam logic [1:0] PRIV_MACH  = 2'd3;

  typedef struct packed {
    logic pendLoad;
    logic claimTry;
    logic claimAccept;
    logic mLevelOn;
    logic sLevelOn;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_pick_ctrl.sv
module irq_pick_ctrl
  import irq_pick_pkg::*;
(
  input  logic        [1:0] privLevel,
  input  logic              mGlobalEn,
  input  logic              sGlobalEn,
  input  logic              pendWrEn,
  input  logic              claimReq,
  input  logic              claimConflict,
  output ctrlStrobe_t       strb
);
  always_comb begin
    strb.pendLoad    = pendWrEn;
    strb.claimTry    = claimReq;
    strb.claimAccept = claimReq && !claimConflict;
    strb.mLevelOn    = (privLevel < PRIV_MACH) || ((privLevel == PRIV_MACH) && mGlobalEn);
    strb.sLevelOn    = (privLevel < PRIV_SUPER) || ((privLevel == PRIV_SUPER) && sGlobalEn);
  end
endmodule

// File: rtl/irq_pick_dp.sv
module irq_pick_dp
  import irq_pick_pkg::*;
#(
  parameter int IRQ_W   = 16,
  parameter int CAUSE_W = $clog2(IRQ_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [IRQ_W-1:0]   pendMask,
  input  logic [IRQ_W-1:0]   pendValue,
  input  logic [IRQ_W-1:0]   enableBits,
  input  logic [IRQ_W-1:0]   delegMask,
  input  logic [IRQ_W-1:0]   claimBits,
  output logic [IRQ_W-1:0]   pendingOut,
  output logic [IRQ_W-1:0]   claimedOut,
  output logic               claimConflict,
  output logic               claimDone,
  output logic               claimOk,
  output logic               takeIrq,
  output logic [CAUSE_W-1:0] causeOut
);
  logic [IRQ_W-1:0]   pendReg, claimedReg;
  logic [IRQ_W-1:0]   candVec, gatedVec;
  logic [CAUSE_W-1:0] lowIdx;

  assign candVec       = pendReg & enableBits;
  assign gatedVec      = (candVec & ~delegMask & {IRQ_W{strb.mLevelOn}}) |
                         (candVec &  delegMask & {IRQ_W{strb.sLevelOn}});
  assign claimConflict = |(claimedReg & claimBits);

  always_comb begin
    lowIdx = '0;
    for (int i = IRQ_W - 1; i >= 0; i--) begin
      if (gatedVec[i]) lowIdx = CAUSE_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg    <= '0;
      claimedReg <= '0;
      claimDone  <= 1'b0;
      claimOk    <= 1'b0;
      takeIrq    <= 1'b0;
      causeOut   <= '0;
    end else begin
      if (strb.pendLoad) pendReg <= (pendReg & ~pendMask) | (pendValue & pendMask);
      if (strb.claimAccept) claimedReg <= claimedReg | claimBits;
      claimDone <= strb.claimTry;
      claimOk   <= strb.claimAccept;
      takeIrq   <= |gatedVec;
      causeOut  <= lowIdx;
    end
  end

  assign pendingOut = pendReg;
  assign claimedOut = claimedReg;

  // R1: a reported line was both pending and enabled at the previous edge
  p_cause_is_candidate_r1: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> ((($past(candVec) >> causeOut) & IRQ_W'(1)) != '0));

  // R6: nothing pending-and-enabled means no interrupt next cycle
  p_idle_when_none_r6: assert property (@(posedge clk) disable iff (!rstN)
    (candVec == '0) |=> (!takeIrq && causeOut == '0));

  p_claim_refused_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.claimTry && (claimedReg & claimBits) != '0) |=> ($stable(claimedReg) && claimDone && !claimOk));

  p_claim_granted_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.claimTry && (claimedReg & claimBits) == '0) |=> (claimOk && (claimedReg & $past(claimBits)) == $past(claimBits)));

  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pendLoad |=> $stable(pendReg));
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pick_pkg::*;
#(
  parameter int IRQ_W   = 16,
  parameter int CAUSE_W = $clog2(IRQ_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pendWrEn,
  input  logic [IRQ_W-1:0]   pendMask,
  input  logic [IRQ_W-1:0]   pendValue,
  input  logic [IRQ_W-1:0]   enableBits,
  input  logic [IRQ_W-1:0]   delegMask,
  input  logic [1:0]         privLevel,
  input  logic               mGlobalEn,
  input  logic               sGlobalEn,
  input  logic               claimReq,
  input  logic [IRQ_W-1:0]   claimBits,
  output logic [IRQ_W-1:0]   pendingOut,
  output logic [IRQ_W-1:0]   claimedOut,
  output logic               claimDone,
  output logic               claimOk,
  output logic               takeIrq,
  output logic [CAUSE_W-1:0] causeOut
);
  ctrlStrobe_t strb;
  logic        claimConflict;

  irq_pick_ctrl ctrl_i (
    .privLevel     (privLevel),
    .mGlobalEn     (mGlobalEn),
    .sGlobalEn     (sGlobalEn),
    .pendWrEn      (pendWrEn),
    .claimReq      (claimReq),
    .claimConflict (claimConflict),
    .strb          (strb)
  );

  irq_pick_dp #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .pendMask      (pendMask),
    .pendValue     (pendValue),
    .enableBits    (enableBits),
    .delegMask     (delegMask),
    .claimBits     (claimBits),
    .pendingOut    (pendingOut),
    .claimedOut    (claimedOut),
    .claimConflict (claimConflict),
    .claimDone     (claimDone),
    .claimOk       (claimOk),
    .takeIrq       (takeIrq),
    .causeOut      (causeOut)
  );

  // R2: below machine level, a pending, enabled, non-delegated line is always taken
  p_mlevel_below_r2: assert property (@(posedge clk) disable iff (!rstN)
    (privLevel != 2'd3 && (pendingOut & enableBits & ~delegMask) != '0) |=> takeIrq);

  // R3: in user mode, a pending, enabled, delegated line is always taken
  p_slevel_user_r3: assert property (@(posedge clk) disable iff (!rstN)
    (privLevel == 2'd0 && (pendingOut & enableBits & delegMask) != '0) |=> takeIrq);
endmodule

// File: tb/irq_pick_tb_top.sv
module irq_pick_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         pendWrEn = 1'b0;
  logic [W-1:0] pendMask = '0, pendValue = '0, enableBits = '0, delegMask = '0, claimBits = '0;
  logic [1:0]   privLevel = 2'd0;
  logic         mGlobalEn = 1'b0, sGlobalEn = 1'b0, claimReq = 1'b0;
  logic [W-1:0] pendingOut, claimedOut;
  logic         claimDone, claimOk, takeIrq;
  logic [3:0]   causeOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_pick dut_i (
    .clk(clk), .rstN(rstN), .pendWrEn(pendWrEn), .pendMask(pendMask), .pendValue(pendValue),
    .enableBits(enableBits), .delegMask(delegMask), .privLevel(privLevel),
    .mGlobalEn(mGlobalEn), .sGlobalEn(sGlobalEn), .claimReq(claimReq), .claimBits(claimBits),
    .pendingOut(pendingOut), .claimedOut(claimedOut), .claimDone(claimDone), .claimOk(claimOk),
    .takeIrq(takeIrq), .causeOut(causeOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [4:0] model(input logic [W-1:0] p, input logic [W-1:0] e,
                                       input logic [W-1:0] d, input logic [1:0] pr,
                                       input logic mg, input logic sg);
    logic mOn, sOn;
    logic [W-1:0] g;
    mOn = (pr != 2'd3) || mg;
    sOn = (pr == 2'd0) || (pr == 2'd1 && sg);
    g = (p & e & ~d & {W{mOn}}) | (p & e & d & {W{sOn}});
    for (int i = 0; i < W; i++) if (g[i]) return {1'b1, 4'(i)};
    return 5'd0;
  endfunction

  task automatic loadPending(input logic [W-1:0] v);
    pendWrEn = 1'b1; pendMask = '1; pendValue = v;
    step();
    pendWrEn = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] pendPat [8];
    logic [W-1:0] delPat  [4];
    logic [W-1:0] enPat   [3];
    logic [W-1:0] model_p, lfsr;
    logic [4:0]   exp5;

    pendPat = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000, 16'h0A50, 16'h00F0, 16'h1248, 16'h0300};
    delPat  = '{16'h0000, 16'hFFFF, 16'h5555, 16'h00AA};
    enPat   = '{16'hFFFF, 16'h0F0F, 16'hF0F0};

    repeat (3) step();
    // R10: reset state
    check("R10 pending", pendingOut, 0);
    check("R10 claimed", claimedOut, 0);
    check("R10 take", {claimDone, claimOk, takeIrq, causeOut}, 0);
    rstN = 1'b1;
    step();

    // R1 R2 R3 R4 R5 R6: sweep
    foreach (pendPat[a]) begin
      loadPending(pendPat[a]);
      foreach (delPat[b]) foreach (enPat[c])
        for (int pr = 0; pr < 4; pr++)
          for (int gb = 0; gb < 4; gb++) begin
            delegMask = delPat[b]; enableBits = enPat[c];
            privLevel = 2'(pr); mGlobalEn = gb[0]; sGlobalEn = gb[1];
            step();
            exp5 = model(pendPat[a], enPat[c], delPat[b], 2'(pr), gb[0], gb[1]);
            check("R5 sweep take/cause (R1 R2 R3 R4 R6)", {takeIrq, causeOut}, exp5);
          end
    end

    // R4: line 2 delegated, line 5 not; machine mode with only the supervisor enable set
    loadPending(16'h0024); enableBits = '1; delegMask = 16'h0004;
    privLevel = 2'd3; mGlobalEn = 1'b0; sGlobalEn = 1'b1; step();
    check("R4 other-level enable ignored", {takeIrq, causeOut}, 5'd0);
    // R3: at supervisor level, line 2 wins over line 5 once the supervisor enable is on
    privLevel = 2'd1; step();
    check("R3 deleg at S", {takeIrq, causeOut}, {1'b1, 4'd2});
    sGlobalEn = 1'b0; step();
    check("R3 S disabled, nondeleg wins", {takeIrq, causeOut}, {1'b1, 4'd5});

    // R9: one-cycle latency
    enableBits = 16'h0000;
    check("R9 output before edge", {takeIrq, causeOut}, {1'b1, 4'd5});
    step();
    check("R9 output after one edge", {takeIrq, causeOut}, 5'd0);

    // R8: masked updates
    loadPending(16'h0000);
    model_p = '0; lfsr = 16'hACE1;
    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] m, v;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; m = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; v = lfsr;
      pendWrEn = (k % 5) != 4; pendMask = m; pendValue = v;
      if (pendWrEn) model_p = (model_p & ~m) | (v & m);
      step();
      check("R8 masked update", pendingOut, model_p);
    end
    pendWrEn = 1'b0;

    // R7: ownership requests
    claimReq = 1'b1; claimBits = 16'h0003; step(); claimReq = 1'b0;
    check("R7 grant first", {claimDone, claimOk, claimedOut}, {2'b11, 16'h0003});
    claimReq = 1'b1; claimBits = 16'h0002; step(); claimReq = 1'b0;
    check("R7 refuse overlap", {claimDone, claimOk, claimedOut}, {2'b10, 16'h0003});
    claimReq = 1'b1; claimBits = 16'h0C00; step(); claimReq = 1'b0;
    check("R7 grant disjoint", {claimDone, claimOk, claimedOut}, {2'b11, 16'h0C03});
    claimReq = 1'b1; claimBits = 16'h8401; step(); claimReq = 1'b0;
    check("R7 refuse partial overlap", {claimDone, claimOk, claimedOut}, {2'b10, 16'h0C03});
    step();
    check("R7 done pulse ends", claimDone, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule